// File: doc/BRIEF.md
# Internal Processor Register Bank

This block holds the processor's internal control registers: a bank of 64-bit entries selected by a dense 8-bit index. Each entry has its own write mask, access rights and side effect. Some entries can only be read. Some can only be written. Some clear on any write. One reads back the live cycle counter. Several do not really store data; writing them only sends a one-cycle command to the translation buffers.

The read port is combinational. A write is committed on the rising clock edge when the commit-valid input is high and the speculative flag is low. A speculative write is dropped without a fault. An access to an undefined index, a write to a read-only entry, or a read of a write-only entry raises a fault flag in the same cycle as the access. Translation-buffer commands are registered pulses: flush everything, flush non-global entries, flush one address with the current address-space number, and insert one data entry. Each pulse is high for the one cycle after the edge that commits the write.

Index map (decimal): 0-7 scratch, 8 vector base, 9 AST request, 10 AST enable, 11 priority level, 12 instruction-side mode, 13 data-side mode, 14 software interrupt request, 15 I-box control, 16 instruction page-table base, 17 data page-table base, 18 cache test control, 19 cache mode, 20 miss-file mode, 21 instruction ASN, 22 data ASN, 23 exception summary, 24 exception mask, 25 interrupt ID, 26 MMU status, 27 cycle count, 28 cycle-count control, 29 miss control, 30 data PTE, 31/32/33 data flush all/process/single, 34/35/36 instruction flush all/process/single, 37 alternate mode, 38 interrupt clear, 39 serial transmit, 40 data-cache flush, 41 instruction-cache flush, 42 serial receive, 43 instruction PTE temp, 44 data PTE temp, 45 data tag/insert. Indices 46-255 are undefined.

Top module: `ipr_bank`

## Requirements
- R1: After reset every entry reads zero, except that index 8 reads the RESET_BASE parameter and index 29 reads 0x6.
- R2: A committed write stores data AND mask: idx 9 and 10 use 0xF, 11 uses 0x1F, 12 and 13 use 0x18, 14 uses 0x7FFF0, 15 uses 0xFFFFFF0300, 16 and 17 use 0xFFFFFFFFC0000000, 18 uses 0x1FFB, 19 and 20 use 0x3F, 21 uses 0x7F0, 22 uses 0xFE00000000000000; 0-8, 27, 29 and 30 store the full word.
- R3: Any committed write to index 23 or 24 leaves the entry zero.
- R4: A committed write to index 25, 26, 42, 43 or 44 raises wr_fault in the same cycle and changes no state.
- R5: Reading index 31-41 or 45 returns zero with rd_fault high.
- R6: Reading index 27 returns the stored bits 63:32 above bits 31:0 of the cycle_cnt input as it is at that moment.
- R7: Any committed write to index 28 makes it read 1.
- R8: Writing 31/32 pulses flush_all[0]/flush_proc[0]. Writing 34/35 pulses flush_all[1]/flush_proc[1]. Each pulse lasts one cycle, after the committing edge. Bit 0 is the data side and bit 1 is the instruction side.
- R9: Writing 33 or 36 pulses flush_one[0] or flush_one[1] with flush_va equal to the written data. flush_asn is bits 63:57 of index 22 for the data side and bits 10:4 of index 21 for the instruction side.
- R10: Reading index 30 returns the stored PTE masked to bits 58:32 (frame number), 15:12 (write enables), 11:8 (read enables), 4 (address-space match), 2 (fault on write) and 1 (fault on read), with bits 63:57 of index 22 placed at bits 63:57.
- R11: Writing index 45 pulses ins_stb for one cycle, with ins_tag equal to the written data and ins_pte equal to the index-30 readback value.
- R12: A write with wr_spec high changes no entry, raises no fault and pulses no strobe.
- R13: Any index of 46 or above gives rd_fault on a read, or wr_fault on a write, and reads zero.
- R14: A read returns the old value while a write to the same index is pending, and the new value after the committing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_idx | input | 8 | Read index |
| rd_data | output | 64 | Read data (combinational) |
| rd_fault | output | 1 | Read index not readable |
| wr_en | input | 1 | Commit-valid for the write |
| wr_spec | input | 1 | Write is speculative; discard it |
| wr_idx | input | 8 | Write index |
| wr_data | input | 64 | Write data |
| wr_fault | output | 1 | Committed write to a non-writable index |
| cycle_cnt | input | 64 | Free-running cycle counter |
| flush_all | output | 2 | Flush-all pulse, [0] data, [1] instruction |
| flush_proc | output | 2 | Flush-process pulse |
| flush_one | output | 2 | Flush-single pulse |
| flush_va | output | 64 | Address for flush-single |
| flush_asn | output | 7 | ASN for flush-single |
| ins_stb | output | 1 | Data entry insert pulse |
| ins_tag | output | 64 | Tag for insert |
| ins_pte | output | 64 | Packed PTE for insert |

## Verification
Every masked register is written with all ones, and each readback must equal its own mask. This tells apart masks that were swapped between indices. The PTE readback is tried twice: once with all ones, and once with a sparse value carrying a junk bit outside every field and a different ASN. This separates a wrong field mask from a wrong ASN source. The flush commands are issued on both sides, each with a different ASN, so a side swap shows in the strobe bit and in flush_asn. Speculative writes, write-only reads, read-only writes and undefined indices are each followed by a readback at the ports.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

    localparam int IDX_W = 8;
    localparam int DW    = 64;
    localparam int NREG  = 46;
    localparam int AW    = $clog2(NREG);

    localparam int I_BASE    = 8;
    localparam int I_ASTREQ  = 9;
    localparam int I_ASTEN   = 10;
    localparam int I_PRIO    = 11;
    localparam int I_IMODE   = 12;
    localparam int I_DMODE   = 13;
    localparam int I_SWREQ   = 14;
    localparam int I_IBOX    = 15;
    localparam int I_IPTB    = 16;
    localparam int I_DPTB    = 17;
    localparam int I_CTEST   = 18;
    localparam int I_CMODE   = 19;
    localparam int I_MFMODE  = 20;
    localparam int I_IASN    = 21;
    localparam int I_DASN    = 22;
    localparam int I_XSUM    = 23;
    localparam int I_XMSK    = 24;
    localparam int I_INTID   = 25;
    localparam int I_MMST    = 26;
    localparam int I_CYC     = 27;
    localparam int I_CYCCTL  = 28;
    localparam int I_MISS    = 29;
    localparam int I_DPTE    = 30;
    localparam int I_DFALL   = 31;
    localparam int I_DFPROC  = 32;
    localparam int I_DFONE   = 33;
    localparam int I_IFALL   = 34;
    localparam int I_IFPROC  = 35;
    localparam int I_IFONE   = 36;
    localparam int I_ALTM    = 37;
    localparam int I_INTCLR  = 38;
    localparam int I_STX     = 39;
    localparam int I_DCFL    = 40;
    localparam int I_ICFL    = 41;
    localparam int I_SRX     = 42;
    localparam int I_ITMP    = 43;
    localparam int I_DTMP    = 44;
    localparam int I_DTAG    = 45;

    localparam logic [DW-1:0] PTE_FIELDS = 64'h07FF_FFFF_0000_FF16;

    typedef enum logic [2:0] {
        WK_NONE, WK_MASK, WK_CLEAR, WK_ONE,
        WK_FALL, WK_FPROC, WK_FONE, WK_INS
    } wkind_t;

    typedef enum logic [1:0] {RK_NONE, RK_PLAIN, RK_CYC, RK_PTE} rkind_t;

    typedef struct packed {
        logic          rd_ok;
        logic          wr_ok;
        rkind_t        rk;
        wkind_t        wk;
        logic          side;
        logic [DW-1:0] mask;
    } attr_t;

endpackage

// File: rtl/ipr_decode.sv
module ipr_decode
    import ipr_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output attr_t            attr
);

    always_comb begin
        attr = '{rd_ok: 1'b0, wr_ok: 1'b0, rk: RK_NONE, wk: WK_NONE,
                 side: 1'b0, mask: '1};
        if (int'(idx) < I_BASE) begin
            attr.rd_ok = 1'b1; attr.rk = RK_PLAIN;
            attr.wr_ok = 1'b1; attr.wk = WK_MASK;
        end else begin
            unique case (int'(idx))
                I_BASE, I_MISS: begin
                    attr.rd_ok = 1'b1; attr.rk = RK_PLAIN;
                    attr.wr_ok = 1'b1; attr.wk = WK_MASK;
                end
                I_ASTREQ, I_ASTEN, I_PRIO, I_IMODE, I_DMODE, I_SWREQ,
                I_IBOX, I_IPTB, I_DPTB, I_CTEST, I_CMODE, I_MFMODE,
                I_IASN, I_DASN: begin
                    attr.rd_ok = 1'b1; attr.rk = RK_PLAIN;
                    attr.wr_ok = 1'b1; attr.wk = WK_MASK;
                    case (int'(idx))
                        I_ASTREQ, I_ASTEN: attr.mask = 64'hF;
                        I_PRIO:            attr.mask = 64'h1F;
                        I_IMODE, I_DMODE:  attr.mask = 64'h18;
                        I_SWREQ:           attr.mask = 64'h7FFF0;
                        I_IBOX:            attr.mask = 64'hFF_FFFF_0300;
                        I_IPTB, I_DPTB:    attr.mask = 64'hFFFF_FFFF_C000_0000;
                        I_CTEST:           attr.mask = 64'h1FFB;
                        I_CMODE, I_MFMODE: attr.mask = 64'h3F;
                        I_IASN:            attr.mask = 64'h7F0;
                        default:           attr.mask = 64'hFE00_0000_0000_0000;
                    endcase
                end
                I_XSUM, I_XMSK: begin
                    attr.rd_ok = 1'b1; attr.rk = RK_PLAIN;
                    attr.wr_ok = 1'b1; attr.wk = WK_CLEAR;
                end
                I_INTID, I_MMST, I_SRX, I_ITMP, I_DTMP: begin
                    attr.rd_ok = 1'b1; attr.rk = RK_PLAIN;
                end
                I_CYC: begin
                    attr.rd_ok = 1'b1; attr.rk = RK_CYC;
                    attr.wr_ok = 1'b1; attr.wk = WK_MASK;
                end
                I_CYCCTL: begin
                    attr.rd_ok = 1'b1; attr.rk = RK_PLAIN;
                    attr.wr_ok = 1'b1; attr.wk = WK_ONE;
                end
                I_DPTE: begin
                    attr.rd_ok = 1'b1; attr.rk = RK_PTE;
                    attr.wr_ok = 1'b1; attr.wk = WK_MASK;
                end
                I_DFALL, I_IFALL: begin
                    attr.wr_ok = 1'b1; attr.wk = WK_FALL;
                    attr.side = (int'(idx) == I_IFALL);
                end
                I_DFPROC, I_IFPROC: begin
                    attr.wr_ok = 1'b1; attr.wk = WK_FPROC;
                    attr.side = (int'(idx) == I_IFPROC);
                end
                I_DFONE, I_IFONE: begin
                    attr.wr_ok = 1'b1; attr.wk = WK_FONE;
                    attr.side = (int'(idx) == I_IFONE);
                end
                I_ALTM: begin
                    attr.wr_ok = 1'b1; attr.wk = WK_MASK; attr.mask = 64'h18;
                end
                I_INTCLR, I_STX, I_DCFL, I_ICFL: begin
                    attr.wr_ok = 1'b1; attr.wk = WK_MASK;
                end
                I_DTAG: begin
                    attr.wr_ok = 1'b1; attr.wk = WK_INS;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ipr_pte_pack.sv
module ipr_pte_pack
    import ipr_pkg::*;
(
    input  logic [DW-1:0] pte_raw,
    input  logic [6:0]    asn,
    output logic [DW-1:0] pte_out
);

    always_comb begin
        pte_out = pte_raw & PTE_FIELDS;
        pte_out[63:57] = asn;
    end

endmodule

// File: rtl/ipr_bank.sv
module ipr_bank
    import ipr_pkg::*;
#(
    parameter logic [63:0] RESET_BASE = 64'h0000_0000_0000_4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data,
    output logic             rd_fault,
    input  logic             wr_en,
    input  logic             wr_spec,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_fault,
    input  logic [DW-1:0]    cycle_cnt,
    output logic [1:0]       flush_all,
    output logic [1:0]       flush_proc,
    output logic [1:0]       flush_one,
    output logic [DW-1:0]    flush_va,
    output logic [6:0]       flush_asn,
    output logic             ins_stb,
    output logic [DW-1:0]    ins_tag,
    output logic [DW-1:0]    ins_pte
);

    logic [DW-1:0] regs [NREG];
    attr_t         rattr, wattr;
    logic [DW-1:0] pte_view;
    logic [6:0]    dasn, iasn;
    logic          commit;
    logic [AW-1:0] ra, wa;

    ipr_decode u_rdec (.idx(rd_idx), .attr(rattr));
    ipr_decode u_wdec (.idx(wr_idx), .attr(wattr));

    assign dasn = regs[I_DASN][63:57];
    assign iasn = regs[I_IASN][10:4];
    assign ra   = rd_idx[AW-1:0];
    assign wa   = wr_idx[AW-1:0];

    ipr_pte_pack u_pack (.pte_raw(regs[I_DPTE]), .asn(dasn), .pte_out(pte_view));

    assign commit   = wr_en && !wr_spec;
    assign wr_fault = commit && !wattr.wr_ok;

    always_comb begin
        rd_data  = '0;
        rd_fault = !rattr.rd_ok;
        if (rattr.rd_ok) begin
            unique case (rattr.rk)
                RK_PLAIN: rd_data = regs[ra];
                RK_CYC:   rd_data = {regs[I_CYC][63:32], cycle_cnt[31:0]};
                RK_PTE:   rd_data = pte_view;
                default:  rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= (i == I_BASE) ? RESET_BASE :
                           (i == I_MISS) ? 64'h6 : '0;
            end
        end else if (commit && wattr.wr_ok) begin
            unique case (wattr.wk)
                WK_MASK:                     regs[wa] <= wr_data & wattr.mask;
                WK_CLEAR, WK_FALL, WK_FPROC: regs[wa] <= '0;
                WK_ONE:                      regs[wa] <= 64'h1;
                WK_FONE, WK_INS:             regs[wa] <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_all  <= '0;
            flush_proc <= '0;
            flush_one  <= '0;
            flush_va   <= '0;
            flush_asn  <= '0;
            ins_stb    <= 1'b0;
            ins_tag    <= '0;
            ins_pte    <= '0;
        end else begin
            flush_all  <= '0;
            flush_proc <= '0;
            flush_one  <= '0;
            ins_stb    <= 1'b0;
            if (commit && wattr.wr_ok) begin
                unique case (wattr.wk)
                    WK_FALL:  flush_all[wattr.side]  <= 1'b1;
                    WK_FPROC: flush_proc[wattr.side] <= 1'b1;
                    WK_FONE: begin
                        flush_one[wattr.side] <= 1'b1;
                        flush_va  <= wr_data;
                        flush_asn <= wattr.side ? iasn : dasn;
                    end
                    WK_INS: begin
                        ins_stb <= 1'b1;
                        ins_tag <= wr_data;
                        ins_pte <= pte_view;
                    end
                    default: ;
                endcase
            end
        end
    end

    logic [6:0] strobes;
    assign strobes = {flush_all, flush_proc, flush_one, ins_stb};

    a_r12_spec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_spec) |=> (strobes == '0));

    a_r4_fault_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fault) |=> (strobes == '0));

    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    a_r8_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes != '0) |-> $past(wr_en && !wr_spec));

    a_r5_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fault |-> (rd_data == '0));

    a_r7_ctl_one: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && int'(wr_idx) == I_CYCCTL) |=> (regs[I_CYCCTL] == 64'h1));

    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (int'(wr_idx) == I_XSUM)) |=> (regs[I_XSUM] == '0));

endmodule

// File: tb/ipr_bank_test.sv
module ipr_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        rd_fault;
    logic        wr_en = 1'b0;
    logic        wr_spec = 1'b0;
    logic [7:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        wr_fault;
    logic [63:0] cycle_cnt = 64'h1234_5678_9ABC_DEF0;
    logic [1:0]  flush_all, flush_proc, flush_one;
    logic [63:0] flush_va;
    logic [6:0]  flush_asn;
    logic        ins_stb;
    logic [63:0] ins_tag, ins_pte;

    localparam logic [63:0] BASE_VAL = 64'h0000_0000_0000_4000;

    int total = 0;
    int bad = 0;
    logic wf;
    logic [1:0] s_all, s_proc, s_one;
    logic s_ins;
    logic [63:0] s_va, s_tag, s_pte;
    logic [6:0]  s_asn;

    always #4 clk = ~clk;

    ipr_bank #(.RESET_BASE(BASE_VAL)) uut (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
        .rd_fault(rd_fault), .wr_en(wr_en), .wr_spec(wr_spec),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_fault(wr_fault),
        .cycle_cnt(cycle_cnt), .flush_all(flush_all), .flush_proc(flush_proc),
        .flush_one(flush_one), .flush_va(flush_va), .flush_asn(flush_asn),
        .ins_stb(ins_stb), .ins_tag(ins_tag), .ins_pte(ins_pte)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [63:0] d, input logic spec);
        @(negedge clk);
        wr_en = 1'b1; wr_spec = spec; wr_idx = idx[7:0]; wr_data = d;
        #1 wf = wr_fault;
        @(posedge clk);
        #1;
        s_all = flush_all; s_proc = flush_proc; s_one = flush_one; s_ins = ins_stb;
        s_va = flush_va; s_asn = flush_asn; s_tag = ins_tag; s_pte = ins_pte;
        wr_en = 1'b0; wr_spec = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [63:0] d, output logic f);
        rd_idx = idx[7:0];
        #1;
        d = rd_data; f = rd_fault;
    endtask

    task automatic t_reset;
        logic [63:0] d; logic f;
        rd(8, d, f);  check("R1 base", d, BASE_VAL);
        rd(29, d, f); check("R1 miss", d, 64'h6);
        rd(0, d, f);  check("R1 scratch", d, 64'h0);
        rd(11, d, f); check("R1 prio", d, 64'h0);
    endtask

    task automatic t_masks;
        int idxs [18] = '{0, 8, 9, 10, 11, 12, 13, 14, 15, 16, 17, 18, 19, 20, 21, 22, 29, 30};
        logic [63:0] m [18] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
            64'hF, 64'hF, 64'h1F, 64'h18, 64'h18, 64'h7FFF0, 64'hFF_FFFF_0300,
            64'hFFFF_FFFF_C000_0000, 64'hFFFF_FFFF_C000_0000, 64'h1FFB, 64'h3F,
            64'h3F, 64'h7F0, 64'hFE00_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
            64'hFFFF_FFFF_0000_FF16};
        logic [63:0] d; logic f;
        for (int k = 0; k < 18; k++) begin
            wr(idxs[k], '1, 1'b0);
            rd(idxs[k], d, f);
            check("R2 mask", d, m[k]);
        end
    endtask

    task automatic t_clear;
        logic [63:0] d; logic f;
        wr(23, 64'hFF, 1'b0); rd(23, d, f); check("R3 sum clear", d, 0);
        wr(24, 64'h5A, 1'b0); rd(24, d, f); check("R3 msk clear", d, 0);
    endtask

    task automatic t_readonly;
        logic [63:0] d; logic f;
        wr(25, 64'h1F, 1'b0); check("R4 fault", {63'b0, wf}, 1);
        rd(25, d, f); check("R4 unchanged", d, 0);
        wr(43, 64'h77, 1'b0); check("R4 fault tmp", {63'b0, wf}, 1);
        rd(43, d, f); check("R4 tmp unchanged", d, 0);
    endtask

    task automatic t_wronly;
        logic [63:0] d; logic f;
        wr(39, 64'hAB, 1'b0); check("R5 write ok", {63'b0, wf}, 0);
        rd(39, d, f); check("R5 data", d, 0); check("R5 fault", {63'b0, f}, 1);
        rd(45, d, f); check("R5 tag fault", {63'b0, f}, 1);
    endtask

    task automatic t_cycle;
        logic [63:0] d; logic f;
        wr(27, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0);
        rd(27, d, f); check("R6 merge", d, 64'hAAAA_BBBB_9ABC_DEF0);
        cycle_cnt = 64'hFFFF_0000_0000_0042;
        rd(27, d, f); check("R6 live", d, 64'hAAAA_BBBB_0000_0042);
        wr(28, 64'h55, 1'b0); rd(28, d, f); check("R7 ctl", d, 1);
    endtask

    task automatic t_flush;
        wr(31, 64'h9, 1'b0);
        check("R8 d all", {62'b0, s_all}, 1); check("R8 d all quiet", {62'b0, s_proc}, 0);
        @(posedge clk); #1; check("R8 one cycle", {62'b0, flush_all}, 0);
        wr(35, 64'h9, 1'b0);
        check("R8 i proc", {62'b0, s_proc}, 2); check("R8 i proc quiet", {62'b0, s_all}, 0);
        wr(22, 64'h0400_0000_0000_0000, 1'b0);
        wr(21, 64'h550, 1'b0);
        wr(33, 64'h1000, 1'b0);
        check("R9 d one", {62'b0, s_one}, 1); check("R9 va", s_va, 64'h1000);
        check("R9 d asn", {57'b0, s_asn}, 2);
        wr(36, 64'h2000, 1'b0);
        check("R9 i one", {62'b0, s_one}, 2); check("R9 i asn", {57'b0, s_asn}, 64'h55);
    endtask

    task automatic t_pte;
        logic [63:0] d; logic f;
        wr(22, 64'h0200_0000_0000_0000, 1'b0);
        wr(30, 64'h0000_0123_0000_A51A, 1'b0);
        rd(30, d, f); check("R10 pte", d, 64'h0200_0123_0000_A512);
        wr(45, 64'hDEAD_0000, 1'b0);
        check("R11 stb", {63'b0, s_ins}, 1); check("R11 tag", s_tag, 64'hDEAD_0000);
        check("R11 pte", s_pte, 64'h0200_0123_0000_A512);
    endtask

    task automatic t_spec;
        logic [63:0] d; logic f;
        wr(1, 64'h77, 1'b1); check("R12 no fault", {63'b0, wf}, 0);
        rd(1, d, f); check("R12 unchanged", d, 0);
        wr(31, 64'h0, 1'b1); check("R12 no strobe", {62'b0, s_all}, 0);
        wr(25, 64'h1, 1'b1); check("R12 ro no fault", {63'b0, wf}, 0);
    endtask

    task automatic t_undef;
        logic [63:0] d; logic f;
        rd(100, d, f); check("R13 rd fault", {63'b0, f}, 1); check("R13 rd zero", d, 0);
        wr(200, 64'h1, 1'b0); check("R13 wr fault", {63'b0, wf}, 1);
        rd(46, d, f); check("R13 edge", {63'b0, f}, 1);
    endtask

    task automatic t_timing;
        @(negedge clk);
        rd_idx = 8'd2; wr_en = 1'b1; wr_idx = 8'd2; wr_data = 64'hABCD;
        #1 check("R14 before", rd_data, 0);
        @(posedge clk); #1;
        wr_en = 1'b0;
        check("R14 after", rd_data, 64'hABCD);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_masks;
        t_clear;
        t_readonly;
        t_wronly;
        t_cycle;
        t_flush;
        t_pte;
        t_spec;
        t_undef;
        t_timing;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule